// File: doc/BRIEF.md
# Nonvolatile Memory Program and Verify Sequencer

This block is the on-chip controller that a device programmer talks to when it writes or reads back the nonvolatile code store. The programmer first holds the reset line high. It then shifts a 10-bit command word into the same line, least significant bit first, one bit per clock. The command picks one of four targets: the user array (2K bytes), the 16-byte scramble key, security bit 1 or security bit 2. The 11-bit byte address is built from one 8-bit port. A select strobe marks the cycles in which the port carries the three upper address bits. The byte data travels over an 8-bit port whose direction follows the high-voltage-present input.

To program, the programmer raises the high-voltage input, presents the byte and gives 25 low-then-high pulses on the program input. The byte is then merged into the store: a programmed bit only ever goes from 1 to 0. To verify, the programmer drops the high-voltage input and holds the address steady. After the settling window, the block drives the read-back byte and raises a valid flag. User bytes are read back XNORed with the key byte chosen by the low four address bits. The two security bits restrict what can be programmed or read.

The storage models the cell array as registers. A separate erase input returns every cell to its blank state.

Top module: `eprom_seq`

## Requirements
- R1: The command receiver is armed only after `rst_ser` has been sampled high on at least 24 consecutive clocks. If `rst_ser` falls before that, the block stays idle with `data_oe` = 0 until `rst_ser` goes high again. While `rst_ser` is held high, `data_oe` and `dout_valid` are 0.
- R2: Once the receiver is armed, the first clock that samples `rst_ser` low is command bit 0, which is 0 in every valid command. Bits 1 to 9 follow on the next nine clocks. The commands are 0x296 (user array), 0x292 (key array), 0x29A (security bit 1) and 0x298 (security bit 2).
- R3: While `addr_sel` is 1, `addr_port[2:0]` is taken as address bits 10..8. The clock that first sees `addr_sel` at 0 commits those bits. While `addr_sel` is 0, `addr_port` is address bits 7..0. The upper bits do not change until the next `addr_sel` pulse.
- R4: In a valid mode with `hv_on` = 0, `dout_valid` rises on the 49th rising clock edge after the low address byte is presented with `addr_sel` low. This is 48 clocks of a stable, captured address. Any address change, `addr_sel` pulse or `hv_on` high withdraws `dout_valid`.
- R5: In user mode, the verify byte is the stored byte XNOR key[address mod 16]. In key mode, it is key[address mod 16]. An erased key (0xFF) therefore returns plain data.
- R6: A byte is committed on the 25th rising edge of `pgm_n` counted while `hv_on` = 1 and `addr_sel` = 0. The new content is old AND `data_in`. The count restarts whenever `hv_on` is 0 or `addr_sel` is 1, so 24 pulses change nothing.
- R7: `data_oe` is 1 in a valid mode while `hv_on` = 0, and 0 while `hv_on` = 1.
- R8: Once security bit 1 is set, committing in user or key mode leaves the store unchanged and key verify is refused. User verify and security verify still work.
- R9: Once security bit 2 is set, both user verify and key verify are refused. A refused verify keeps `dout_valid` = 0 and `data_out` = 0x00.
- R10: In either security mode, a commit sets that mode's bit. Verify returns bit 7 = security bit 1 and bit 6 = security bit 2, with 1 meaning set and the other bits 0.
- R11: `erase` = 1 at a clock edge sets every user and key byte to 0xFF and clears both security bits.
- R12: A 10-bit command other than the four listed leaves the block idle (`data_oe` = 0, `dout_valid` = 0) until `rst_ser` goes high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also strobes the serial command bits |
| rst_ser | input | 1 | Reset level and serial command input |
| erase | input | 1 | Returns the whole store to blank |
| addr_sel | input | 1 | High: port carries address bits 10..8 |
| addr_port | input | 8 | Multiplexed address port |
| data_in | input | 8 | Byte to program |
| data_out | output | 8 | Verify byte, 0 when not valid |
| data_oe | output | 1 | 1 when the data port drives outward |
| dout_valid | output | 1 | Verify byte is settled and permitted |
| pgm_n | input | 1 | Program pulse input, idle high |
| hv_on | input | 1 | Programming voltage present |

## Verification
The read-back port has no back-pressure. `dout_valid` is a level that holds as long as the address and `hv_on` stay put, and the programmer samples whenever it is high. The checker takes for granted that `erase` is the only path back to blank cells. It also assumes `rst_ser` is the only way out of the idle state entered on a bad command. The stimulus therefore changes store contents only through pulse bursts with `hv_on` high and a settled address. It always starts a new command with a reset hold. Every address change goes through an `addr_sel` pulse, so each verify produces a fresh rising edge of `dout_valid` for the scoreboard.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;
  localparam int CODE_W = 10;

  localparam logic [CODE_W-1:0] CMD_USER = 10'h296;
  localparam logic [CODE_W-1:0] CMD_KEY  = 10'h292;
  localparam logic [CODE_W-1:0] CMD_SEC1 = 10'h29A;
  localparam logic [CODE_W-1:0] CMD_SEC2 = 10'h298;

  typedef enum logic [2:0] {
    MD_NONE,
    MD_USER,
    MD_KEY,
    MD_SEC1,
    MD_SEC2
  } mode_e;
endpackage

// File: rtl/mode_rx.sv
module mode_rx
  import eprom_seq_pkg::*;
#(
  parameter int HOLD_MIN = 24
) (
  input  logic  clk,
  input  logic  rst_ser,
  output mode_e mode,
  output logic  bad
);
  localparam int HW = $clog2(HOLD_MIN + 1);
  localparam int BW = $clog2(CODE_W);

  typedef enum logic [1:0] {S_HOLD, S_SHIFT, S_RUN, S_BAD} rx_st_e;

  rx_st_e            st;
  logic [HW-1:0]     hold_cnt;
  logic [BW-1:0]     bit_idx;
  logic [CODE_W-1:0] shreg;
  logic [CODE_W-1:0] full_code;
  mode_e             dec;
  mode_e             mode_q;

  assign full_code = {rst_ser, shreg[CODE_W-2:0]};

  always_comb begin
    case (full_code)
      CMD_USER: dec = MD_USER;
      CMD_KEY:  dec = MD_KEY;
      CMD_SEC1: dec = MD_SEC1;
      CMD_SEC2: dec = MD_SEC2;
      default:  dec = MD_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    case (st)
      S_HOLD: begin
        mode_q <= MD_NONE;
        if (rst_ser) begin
          if (hold_cnt != HW'(HOLD_MIN)) hold_cnt <= hold_cnt + 1'b1;
        end else if (hold_cnt == HW'(HOLD_MIN)) begin
          // this low sample is command bit 0
          st      <= S_SHIFT;
          shreg   <= '0;
          bit_idx <= BW'(1);
        end else begin
          st <= S_BAD;
        end
      end
      S_SHIFT: begin
        shreg[bit_idx] <= rst_ser;
        if (bit_idx == BW'(CODE_W - 1)) begin
          if (dec == MD_NONE) st <= S_BAD;
          else begin
            st     <= S_RUN;
            mode_q <= dec;
          end
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
      default: begin
        if (rst_ser) begin
          st       <= S_HOLD;
          hold_cnt <= HW'(1);
          mode_q   <= MD_NONE;
        end
      end
    endcase
  end

  assign mode = mode_q;
  assign bad  = (st == S_BAD);
endmodule

// File: rtl/addr_capture.sv
module addr_capture #(
  parameter int AW   = 11,
  parameter int LO_W = 8,
  parameter int LAT  = 48
) (
  input  logic          clk,
  input  logic          addr_sel,
  input  logic [LO_W-1:0] port,
  input  logic          meas_en,
  output logic [AW-1:0] addr,
  output logic          stable
);
  localparam int HI_W = AW - LO_W;
  localparam int CW   = $clog2(LAT + 1);

  logic [HI_W-1:0] hi_pend, hi_q;
  logic [LO_W-1:0] lo_q;
  logic            sel_d;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    sel_d <= addr_sel;
    if (addr_sel) hi_pend <= port[HI_W-1:0];
    if (sel_d && !addr_sel) hi_q <= hi_pend;
    if (!addr_sel) lo_q <= port;
    if (!meas_en || addr_sel || (port != lo_q)) cnt <= '0;
    else if (cnt != CW'(LAT)) cnt <= cnt + 1'b1;
  end

  assign addr   = {hi_q, lo_q};
  assign stable = (cnt == CW'(LAT));
endmodule

// File: rtl/pulse_count.sv
module pulse_count #(
  parameter int PULSES = 25
) (
  input  logic clk,
  input  logic pgm_n,
  input  logic arm,
  output logic commit
);
  localparam int PW = $clog2(PULSES);

  logic          pgm_q;
  logic [PW-1:0] cnt;
  logic          rise;

  assign rise   = !pgm_q && pgm_n;
  assign commit = arm && rise && (cnt == PW'(PULSES - 1));

  always_ff @(posedge clk) begin
    pgm_q <= pgm_n;
    if (!arm) cnt <= '0;
    else if (rise) cnt <= (cnt == PW'(PULSES - 1)) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/nv_store.sv
module nv_store #(
  parameter int AW   = 11,
  parameter int DW   = 8,
  parameter int KEYN = 16
) (
  input  logic          clk,
  input  logic          erase,
  input  logic          wr_user,
  input  logic          wr_key,
  input  logic          set_s1,
  input  logic          set_s2,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] user_rd,
  output logic [DW-1:0] key_rd,
  output logic          sec1,
  output logic          sec2
);
  localparam int DEPTH = 1 << AW;
  localparam int KW    = $clog2(KEYN);

  logic [DW-1:0] ucell [DEPTH];
  logic [DW-1:0] kcell [KEYN];
  logic          s1_q, s2_q;
  logic [KW-1:0] kidx;

  assign kidx = addr[KW-1:0];

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) ucell[i] <= '1;
      for (int j = 0; j < KEYN; j++) kcell[j] <= '1;
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      if (wr_user) ucell[addr] <= ucell[addr] & wdata;
      if (wr_key)  kcell[kidx] <= kcell[kidx] & wdata;
      if (set_s1)  s1_q <= 1'b1;
      if (set_s2)  s2_q <= 1'b1;
    end
  end

  assign user_rd = ucell[addr];
  assign key_rd  = kcell[kidx];
  assign sec1    = s1_q;
  assign sec2    = s2_q;
endmodule

// File: rtl/eprom_seq.sv
module eprom_seq
  import eprom_seq_pkg::*;
#(
  parameter int AW       = 11,
  parameter int DW       = 8,
  parameter int KEYN     = 16,
  parameter int HOLD_MIN = 24,
  parameter int LAT      = 48,
  parameter int PULSES   = 25
) (
  input  logic          clk,
  input  logic          rst_ser,
  input  logic          erase,
  input  logic          addr_sel,
  input  logic [7:0]    addr_port,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          dout_valid,
  input  logic          pgm_n,
  input  logic          hv_on
);
  mode_e         mode;
  logic          rx_bad;
  logic [AW-1:0] addr_q;
  logic          stable;
  logic          commit;
  logic          meas_en, arm;
  logic          wr_user, wr_key, set_s1, set_s2;
  logic [DW-1:0] user_rd, key_rd;
  logic          sec1, sec2;
  logic [DW-1:0] vdata;
  logic          permit;

  assign meas_en = (mode != MD_NONE) && !hv_on;
  assign arm     = hv_on && (mode != MD_NONE) && !addr_sel;

  mode_rx #(.HOLD_MIN(HOLD_MIN)) u_rx (
    .clk(clk), .rst_ser(rst_ser), .mode(mode), .bad(rx_bad)
  );

  addr_capture #(.AW(AW), .LO_W(8), .LAT(LAT)) u_addr (
    .clk(clk), .addr_sel(addr_sel), .port(addr_port),
    .meas_en(meas_en), .addr(addr_q), .stable(stable)
  );

  pulse_count #(.PULSES(PULSES)) u_pulse (
    .clk(clk), .pgm_n(pgm_n), .arm(arm), .commit(commit)
  );

  assign wr_user = commit && (mode == MD_USER) && !sec1;
  assign wr_key  = commit && (mode == MD_KEY) && !sec1;
  assign set_s1  = commit && (mode == MD_SEC1);
  assign set_s2  = commit && (mode == MD_SEC2);

  nv_store #(.AW(AW), .DW(DW), .KEYN(KEYN)) u_store (
    .clk(clk), .erase(erase), .wr_user(wr_user), .wr_key(wr_key),
    .set_s1(set_s1), .set_s2(set_s2), .addr(addr_q), .wdata(data_in),
    .user_rd(user_rd), .key_rd(key_rd), .sec1(sec1), .sec2(sec2)
  );

  always_comb begin
    vdata  = '0;
    permit = 1'b0;
    case (mode)
      MD_USER: begin
        vdata  = ~(user_rd ^ key_rd);
        permit = !sec2;
      end
      MD_KEY: begin
        vdata  = key_rd;
        permit = !sec1 && !sec2;
      end
      MD_SEC1, MD_SEC2: begin
        vdata[DW-1] = sec1;
        vdata[DW-2] = sec2;
        permit      = 1'b1;
      end
      default: ;
    endcase
  end

  assign dout_valid = stable && permit;
  assign data_out   = dout_valid ? vdata : '0;
  assign data_oe    = (mode != MD_NONE) && !hv_on;
endmodule

// File: rtl/eprom_seq_chk.sv
module eprom_seq_chk #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_ser,
  input logic          erase,
  input logic          hv_on,
  input logic          dout_valid,
  input logic          rx_bad,
  input logic          sec1,
  input logic          sec2,
  input logic [AW-1:0] addr_q,
  input logic [DW-1:0] user_rd
);
  // R4: a settled verify byte needs the voltage low on the previous clock
  a_r4_valid_needs_low_hv: assert property (@(posedge clk) disable iff (rst_ser)
    dout_valid |-> !$past(hv_on));

  // R6: programming only clears bits of the addressed byte
  a_r6_bits_only_clear: assert property (@(posedge clk) disable iff (rst_ser)
    (!$past(erase) && $stable(addr_q)) |-> ((user_rd & ~$past(user_rd)) == '0));

  // R8: security bit 1 freezes the user array
  a_r8_sec1_freezes_user: assert property (@(posedge clk) disable iff (rst_ser)
    ($past(sec1) && !$past(erase) && $stable(addr_q)) |-> $stable(user_rd));

  // R10: security bits are sticky until erase
  a_r10_sec_sticky: assert property (@(posedge clk) disable iff (rst_ser)
    !$past(erase) |-> ((sec1 || !$past(sec1)) && (sec2 || !$past(sec2))));

  // R12: a rejected command stays idle until the line rises again
  a_r12_bad_sticky: assert property (@(posedge clk) disable iff (rst_ser)
    ($past(rx_bad) && !$past(rst_ser)) |-> rx_bad);
endmodule

bind eprom_seq eprom_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_ser(rst_ser), .erase(erase), .hv_on(hv_on),
  .dout_valid(dout_valid), .rx_bad(rx_bad), .sec1(sec1), .sec2(sec2),
  .addr_q(addr_q), .user_rd(user_rd)
);

// File: tb/sim_eprom_seq.sv
module sim_eprom_seq;
  logic       clk = 1'b0;
  logic       rst_ser, erase, addr_sel, pgm_n, hv_on;
  logic [7:0] addr_port, data_in, data_out;
  logic       data_oe, dout_valid;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] q_exp[$];
  string      q_tag[$];
  logic       prev_v = 1'b0;

  always #5 clk = ~clk;

  eprom_seq u0 (
    .clk(clk), .rst_ser(rst_ser), .erase(erase), .addr_sel(addr_sel),
    .addr_port(addr_port), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .dout_valid(dout_valid), .pgm_n(pgm_n), .hv_on(hv_on)
  );

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: each new verify byte is compared against the scoreboard
  always @(negedge clk) begin
    if (dout_valid && !prev_v && q_exp.size() != 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(data_out == e, t, data_out, e);
    end
    prev_v = dout_valid;
  end

  // R1/R2: hold, then ten command bits LSB first
  task automatic enter(input logic [9:0] code, input int hold);
    rst_ser = 1'b1;
    tick(hold);
    for (int i = 0; i < 10; i++) begin
      rst_ser = code[i];
      tick(1);
    end
    rst_ser = 1'b0;
    tick(2);
  endtask

  task automatic set_addr(input logic [10:0] a);
    addr_sel  = 1'b1;
    addr_port = {5'b0, a[10:8]};
    tick(2);
    addr_sel  = 1'b0;
    addr_port = a[7:0];
  endtask

  task automatic prog(input logic [7:0] d, input int n);
    hv_on   = 1'b1;
    data_in = d;
    tick(1);
    for (int i = 0; i < n; i++) begin
      pgm_n = 1'b0;
      tick(1);
      pgm_n = 1'b1;
      tick(1);
    end
    hv_on = 1'b0;
    tick(1);
  endtask

  task automatic verify(input logic [10:0] a, input logic [7:0] exp, input string tag);
    set_addr(a);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    tick(60);
  endtask

  task automatic no_verify(input logic [10:0] a, input string tag);
    set_addr(a);
    tick(60);
    check(!dout_valid && data_out == 8'h00, tag, {7'b0, dout_valid}, 8'h00);
  endtask

  initial begin
    #(200000 * 10);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_ser = 1'b1; erase = 1'b1; addr_sel = 1'b0; addr_port = 8'h00;
    data_in = 8'h00; pgm_n = 1'b1; hv_on = 1'b0;
    tick(2);
    erase = 1'b0;
    tick(3);
    check(!data_oe && !dout_valid, "R1 reset state", {data_oe, dout_valid}, 8'h00);

    enter(10'h296, 10);
    tick(60);
    check(!data_oe, "R1 short hold", {7'b0, data_oe}, 8'h00);

    enter(10'h2F0, 30);
    tick(60);
    check(!data_oe && !dout_valid, "R12 unknown code", {data_oe, dout_valid}, 8'h00);

    enter(10'h296, 30);
    check(data_oe, "R7 output in verify", {7'b0, data_oe}, 8'h01);
    set_addr(11'h5A3);
    q_exp.push_back(8'hFF);
    q_tag.push_back("R4 blank read");
    tick(48);
    check(!dout_valid, "R4 not before 49 edges", {7'b0, dout_valid}, 8'h00);
    tick(1);
    check(dout_valid, "R4 valid at 49 edges", {7'b0, dout_valid}, 8'h01);
    tick(10);
    hv_on = 1'b1;
    tick(1);
    check(!data_oe && !dout_valid, "R7 input while hv", {data_oe, dout_valid}, 8'h00);
    hv_on = 1'b0;
    tick(1);

    prog(8'h3C, 25);
    verify(11'h5A3, 8'h3C, "R6 program");
    prog(8'hF0, 25);
    verify(11'h5A3, 8'h30, "R6 and merge");
    set_addr(11'h010);
    tick(2);
    prog(8'h00, 24);
    verify(11'h010, 8'hFF, "R6 24 pulses");

    verify(11'h2A3, 8'hFF, "R3 new high bits");
    prog(8'h81, 25);
    verify(11'h2A3, 8'h81, "R3 program high page");
    verify(11'h5A3, 8'h30, "R3 other page intact");

    enter(10'h292, 30);
    set_addr(11'h003);
    tick(2);
    prog(8'h0F, 25);
    verify(11'h013, 8'h0F, "R5 key index mod 16");
    verify(11'h004, 8'hFF, "R5 other key blank");

    enter(10'h296, 30);
    verify(11'h5A3, 8'hC0, "R5 xnor scramble");
    verify(11'h2A3, 8'h71, "R5 xnor scramble 2");

    enter(10'h29A, 30);
    verify(11'h000, 8'h00, "R10 none set");
    prog(8'h00, 25);
    verify(11'h001, 8'h80, "R10 bit1 set");

    enter(10'h296, 30);
    set_addr(11'h5A3);
    tick(2);
    prog(8'h00, 25);
    verify(11'h5A3, 8'hC0, "R8 user locked, verify allowed");

    enter(10'h292, 30);
    no_verify(11'h003, "R8 key verify refused");
    prog(8'h00, 25);

    enter(10'h296, 30);
    verify(11'h5A3, 8'hC0, "R8 key program refused");

    enter(10'h298, 30);
    set_addr(11'h000);
    tick(2);
    prog(8'h00, 25);
    verify(11'h002, 8'hC0, "R10 both bits");
    enter(10'h29A, 30);
    verify(11'h003, 8'hC0, "R2 command 29A");

    enter(10'h296, 30);
    no_verify(11'h5A3, "R9 user verify refused");

    erase = 1'b1;
    tick(1);
    erase = 1'b0;
    verify(11'h5A3, 8'hFF, "R11 erased user");
    enter(10'h29A, 30);
    verify(11'h000, 8'h00, "R11 security cleared");

    check(q_exp.size() == 0, "R4 every verify delivered", 8'(q_exp.size()), 8'h00);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule